// File: doc/BRIEF.md
# Selectable Test Clock Generator

This block derives the test clock (TCK) of a debug probe from a fixed reference clock. A speed code picks the rate. Nine codes give fixed frequencies, from 6 MHz down to 10 kHz, by dividing the reference clock. One code gives adaptive clocking: the block starts each TCK edge only after the target has echoed the previous edge on its returned clock (RTCK). A probe can therefore start slowly after reset and switch to a faster code once the target's clocks are set up. The speed code may change while TCK is running.

A run request starts and stops TCK. The block gives the shift logic a one-cycle strobe for every rising TCK edge. In adaptive mode a wait timer raises an error flag when the target stops answering. A new code is taken in only at a falling TCK edge, so every TCK phase has the full length of one code and no shortened pulse reaches the target.

Top module: `tck_gen`

## Requirements
- R1: While reset is asserted, `tck_o`, `bit_stb_o` and `timeout_o` are low. After reset, with `run_i` low, `tck_o` stays low.
- R2: With the default 48 MHz reference, codes 1, 2, 3 and 4 (6 MHz, 3 MHz, 1 MHz, 500 kHz) hold each TCK high phase and each low phase for 4, 8, 24 and 48 reference cycles respectively.
- R3: Codes 5, 6, 7, 8 and 9 (200 kHz, 100 kHz, 50 kHz, 20 kHz, 10 kHz) give half-periods of 120, 240, 480, 1200 and 2400 reference cycles.
- R4: Codes 10 to 15 run at the slowest rate, a half-period of 2400 cycles.
- R5: The speed code is sampled at each falling TCK edge, and on every cycle while the block is idle. A code that changes during a high phase leaves that high phase at its old length. The new code governs the low phase that follows.
- R6: `bit_stb_o` is high for exactly the first reference cycle of each TCK high phase and is low at all other times.
- R7: If `run_i` falls during a high phase, that phase still lasts its full length. TCK then stays low and no strobe is produced. Raising `run_i` again resumes normal periods.
- R8: Code 0 selects adaptive clocking. RTCK passes through a synchronizer of `SYNC_STAGES` flops (default 2). A TCK edge is issued only when the synchronized RTCK equals the present TCK level. Suppose RTCK takes the new level partway through the n-th cycle after a TCK edge, counting from n = 0. The next edge then comes n + 3 cycles after the previous one.
- R9: In the fixed-rate codes, `rtck_i` has no effect on TCK timing, and `timeout_o` stays low.
- R10: In adaptive mode, `timeout_o` rises exactly `TIMEOUT_CYC` cycles (default 65536) after a TCK edge that RTCK has not matched. TCK holds its level while it waits. The flag stays set while running and clears once `run_i` is low and TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Request to produce TCK |
| speed_i | input | CODE_W (4) | Speed code: 0 adaptive, 1..9 fixed rates, 10..15 slowest |
| rtck_i | input | 1 | Returned clock from the target, asynchronous |
| tck_o | output | 1 | Test clock |
| bit_stb_o | output | 1 | One-cycle strobe at each rising TCK edge |
| timeout_o | output | 1 | Adaptive wait timed out (sticky while running) |

## Verification
TCK, the strobe and the flag all leave registers that update on the same edge. A fixed half-period therefore appears as exactly N consecutive mid-cycle samples at one level. The strobe must coincide with the first high sample.

In adaptive runs the bench's target model echoes TCK a chosen number of half-cycles later. The expected phase length is that delay plus the synchronizer stages plus one decision cycle. The flag is expected on the sample that lies `TIMEOUT_CYC` cycles past the unanswered edge. Every measurement starts at an observed TCK edge, so the checks never rely on absolute time.

// File: rtl/tckgen_pkg.sv
`timescale 1ns/1ps
package tckgen_pkg;

   localparam int unsigned ADAPTIVE_CODE = 0;
   localparam int unsigned SLOWEST_CODE  = 9;

   // Target TCK frequency for a fixed-rate speed code; out-of-range codes run slowest.
   function automatic int unsigned code_hz(input int unsigned code);
      case (code)
         1:       return 6_000_000;
         2:       return 3_000_000;
         3:       return 1_000_000;
         4:       return 500_000;
         5:       return 200_000;
         6:       return 100_000;
         7:       return 50_000;
         8:       return 20_000;
         default: return 10_000;
      endcase
   endfunction

   // Reference cycles per TCK half-period.
   function automatic int unsigned half_cnt(input int unsigned ref_hz, input int unsigned code);
      return ref_hz / (2 * code_hz(code));
   endfunction

endpackage

// File: rtl/tckgen_rate_lut.sv
`timescale 1ns/1ps
module tckgen_rate_lut
   import tckgen_pkg::*;
#(
   parameter int unsigned REF_HZ = 48_000_000,
   parameter int          CODE_W = 4,
   parameter int          CNT_W  = 12
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  half_o,
   output logic              adapt_o
);
   localparam int N_CODES = 2 ** CODE_W;

   logic [CNT_W-1:0] tab [N_CODES];

   generate
      for (genvar g = 0; g < N_CODES; g++) begin : g_tab
         assign tab[g] = CNT_W'(half_cnt(REF_HZ, g));
      end
      if (half_cnt(REF_HZ, 1) < 1) begin : g_chk_ref
         $error("reference clock too slow for the fastest rate");
      end
      if (half_cnt(REF_HZ, SLOWEST_CODE) >= (2 ** CNT_W)) begin : g_chk_w
         $error("counter width too small for the slowest rate");
      end
   endgenerate

   assign half_o  = tab[code_i];
   assign adapt_o = (code_i == CODE_W'(ADAPTIVE_CODE));
endmodule

// File: rtl/tckgen_sync.sv
`timescale 1ns/1ps
module tckgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES < 2) begin : g_chk
         $error("synchronizer needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[0] <= 1'b0;
               else        ff_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[s] <= 1'b0;
               else        ff_q[s] <= ff_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tckgen_wait_timer.sv
`timescale 1ns/1ps
module tckgen_wait_timer #(
   parameter int unsigned TIMEOUT_CYC = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting_i,
   input  logic clear_i,
   output logic expired_o
);
   localparam int W = $clog2(TIMEOUT_CYC + 1);

   logic [W-1:0] cnt_q;
   logic         exp_q;

   generate
      if (TIMEOUT_CYC < 2) begin : g_chk
         $error("timeout must be at least two cycles");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!waiting_i) begin
         cnt_q <= '0;
      end else if (cnt_q != W'(TIMEOUT_CYC)) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= 1'b0;
      end else if (clear_i) begin
         exp_q <= 1'b0;
      end else if (waiting_i && cnt_q == W'(TIMEOUT_CYC - 1)) begin
         exp_q <= 1'b1;
      end
   end

   assign expired_o = exp_q;

   AST_EXPIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !clear_i) |=> expired_o); // R10
endmodule

// File: rtl/tck_gen.sv
`timescale 1ns/1ps
module tck_gen
   import tckgen_pkg::*;
#(
   parameter int unsigned REF_HZ      = 48_000_000,
   parameter int          CODE_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT_CYC = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [CODE_W-1:0] speed_i,
   input  logic              rtck_i,
   output logic              tck_o,
   output logic              bit_stb_o,
   output logic              timeout_o
);
   localparam int unsigned HALF_MAX = half_cnt(REF_HZ, SLOWEST_CODE);
   localparam int          CNT_W    = $clog2(HALF_MAX + 1);

   generate
      if (CODE_W < 4) begin : g_chk_code
         $error("speed code must be at least four bits wide");
      end
   endgenerate

   logic              tck_q, stb_q;
   logic [CODE_W-1:0] act_code_q;
   logic [CNT_W-1:0]  cnt_q, half_w;
   logic              adapt_w, rtck_s;
   logic              advance_w, idle_w, step_w, waiting_w, expired_w;

   tckgen_rate_lut #(.REF_HZ(REF_HZ), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_lut (
      .code_i (act_code_q),
      .half_o (half_w),
      .adapt_o(adapt_w)
   );

   tckgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (rtck_i),
      .q_o  (rtck_s)
   );

   tckgen_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .waiting_i(waiting_w),
      .clear_i  (idle_w),
      .expired_o(expired_w)
   );

   // A high phase always runs to completion, even after run_i drops.
   always_comb begin
      advance_w = run_i | tck_q;
      idle_w    = ~advance_w;
      if (adapt_w) step_w = advance_w && (rtck_s == tck_q);
      else         step_w = advance_w && (cnt_q == half_w - CNT_W'(1));
      waiting_w = advance_w && adapt_w && (rtck_s != tck_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tck_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= step_w && !tck_q;
         if (step_w) tck_q <= ~tck_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!advance_w || adapt_w || step_w) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + CNT_W'(1);
   end

   // New rate enters only at a falling edge or while idle: no shortened phase.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       act_code_q <= CODE_W'(SLOWEST_CODE);
      else if (idle_w || (step_w && tck_q)) act_code_q <= speed_i;
   end

   assign tck_o     = tck_q;
   assign bit_stb_o = stb_q;
   assign timeout_o = expired_w;

   AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb_o |-> (tck_o && !$past(tck_o))); // R6
   AST_IDLE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !tck_o) |=> !tck_o); // R7
   AST_CODE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tck_o && $past(tck_o)) |-> (act_code_q == $past(act_code_q))); // R5
   AST_ADAPT_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adapt_w) && (tck_o != $past(tck_o))) |-> ($past(rtck_s) == $past(tck_o))); // R8
   AST_TIMEOUT_ADAPT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(adapt_w)); // R10
endmodule

// File: tb/tb_tck_gen.sv
`timescale 1ns/1ps
module tb_tck_gen;
   localparam int TOUT = 1024;
   localparam int WD   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_i = 1'b0;
   logic [3:0] speed_i = 4'd1;
   logic       rtck_i = 1'b0;
   logic       tck_o, bit_stb_o, timeout_o;

   int  vectors = 0, fails = 0;
   bit  done = 1'b0, reported = 1'b0;
   bit  t_prev = 1'b0, t_cur = 1'b0;
   int  rmode = 1;   // 0 echo, 1 stuck low, 2 noise
   int  dly = 1;
   logic [7:0] hist = '0;
   logic [3:0] ncnt = '0;

   always #2.5 clk = ~clk;

   tck_gen #(.TIMEOUT_CYC(TOUT)) dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .speed_i(speed_i),
      .rtck_i(rtck_i), .tck_o(tck_o), .bit_stb_o(bit_stb_o), .timeout_o(timeout_o)
   );

   // Target model: RTCK follows TCK by dly half-cycle-offset samples.
   always @(negedge clk) begin
      hist = {hist[6:0], tck_o};
      ncnt = ncnt + 4'd1;
      case (rmode)
         0:       rtck_i = hist[dly-1];
         1:       rtck_i = 1'b0;
         default: rtck_i = ncnt[2] ^ ncnt[0];
      endcase
   end

   function automatic int exp_half(input int c);
      int f;
      case (c)
         1: f = 6000000;  2: f = 3000000;  3: f = 1000000;
         4: f = 500000;   5: f = 200000;   6: f = 100000;
         7: f = 50000;    8: f = 20000;
         default: f = 10000;
      endcase
      return 48000000 / (2 * f);
   endfunction

   task automatic chk(input string req, input string what, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic finish_up();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   // One mid-cycle sample; R6 strobe checked on every sample.
   task automatic step_s();
      bit e;
      @(negedge clk);
      t_prev = t_cur;
      t_cur  = tck_o;
      e = t_cur && !t_prev;
      if (e || (bit_stb_o !== e)) chk("R6", "strobe at rising edge", int'(bit_stb_o), int'(e));
   endtask

   task automatic wait_rise();
      do step_s(); while (!(t_cur && !t_prev));
   endtask

   task automatic wait_fall();
      do step_s(); while (!(!t_cur && t_prev));
   endtask

   task automatic measure(output int hi, output int lo);
      hi = 0; lo = 0;
      while (t_cur)  begin hi++; step_s(); end
      while (!t_cur) begin lo++; step_s(); end
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         finish_up();
      end
   end

   initial begin
      int hi, lo, n, rises;
      string rq;
      repeat (4) @(negedge clk);
      chk("R1", "tck in reset", int'(tck_o), 0);
      chk("R1", "strobe in reset", int'(bit_stb_o), 0);
      chk("R1", "timeout in reset", int'(timeout_o), 0);
      rst_n = 1'b1;
      repeat (6) step_s();
      chk("R1", "tck idle after reset", int'(tck_o), 0);

      // Fixed-rate sweep with RTCK noise (R9)
      rmode = 2;
      run_i = 1'b1;
      for (int c = 1; c < 16; c++) begin
         speed_i = 4'(c);
         wait_fall();
         wait_rise();
         measure(hi, lo);
         rq = (c < 5) ? "R2" : ((c < 10) ? "R3" : "R4");
         chk(rq, $sformatf("code %0d high", c), hi, exp_half(c));
         chk(rq, $sformatf("code %0d low", c), lo, exp_half(c));
      end
      chk("R9", "timeout quiet in fixed modes", int'(timeout_o), 0);

      // R5: code change during a high phase
      speed_i = 4'd5;
      wait_fall();
      wait_rise();
      speed_i = 4'd1;
      measure(hi, lo);
      chk("R5", "old high kept", hi, 120);
      chk("R5", "new low applied", lo, 4);
      measure(hi, lo);
      chk("R5", "new high", hi, 4);

      // R7: stop during high phase, then restart
      speed_i = 4'd2;
      wait_fall();
      wait_rise();
      run_i = 1'b0;
      hi = 0;
      while (t_cur) begin hi++; step_s(); end
      chk("R7", "high completes after stop", hi, 8);
      rises = 0;
      for (int i = 0; i < 60; i++) begin
         step_s();
         if (t_cur && !t_prev) rises++;
      end
      chk("R7", "no edges while stopped", rises, 0);
      chk("R7", "tck low while stopped", int'(tck_o), 0);
      run_i = 1'b1;
      wait_rise();
      measure(hi, lo);
      chk("R7", "restart high", hi, 8);
      chk("R7", "restart low", lo, 8);

      // R8: adaptive handshake with various echo delays
      rmode = 0;
      speed_i = 4'd0;
      for (int d = 1; d < 8; d += 2) begin
         dly = d;
         wait_fall();
         wait_fall();
         wait_rise();
         measure(hi, lo);
         chk("R8", $sformatf("adaptive high delay %0d", d), hi, d + 2);
         chk("R8", $sformatf("adaptive low delay %0d", d), lo, d + 2);
      end
      chk("R10", "no timeout with answering target", int'(timeout_o), 0);

      // R10: target stops answering
      run_i = 1'b0;
      repeat (40) step_s();
      rmode = 1;
      repeat (6) step_s();
      run_i = 1'b1;
      wait_rise();
      n = 0;
      while (!timeout_o && t_cur && n < TOUT + 10) begin n++; step_s(); end
      chk("R10", "cycles to timeout", n, TOUT);
      chk("R10", "tck held while waiting", int'(t_cur), 1);
      rmode = 0;
      dly = 1;
      wait_rise();
      measure(hi, lo);
      chk("R10", "resumes after echo high", hi, 3);
      chk("R10", "flag sticky while running", int'(timeout_o), 1);
      run_i = 1'b0;
      repeat (20) step_s();
      chk("R10", "flag cleared when idle", int'(timeout_o), 0);
      chk("R7", "tck low when idle", int'(tck_o), 0);

      done = 1'b1;
      finish_up();
   end
endmodule